// File: doc/BRIEF.md
# Manchester Line Decoder with Hold-Off Clock Recovery

This block turns a squared Manchester-coded line signal back into NRZ data. It runs from a fast sample clock, `OVERSAMPLE` times the bit rate. It recovers the bit clock with a digital stand-in for a one-shot timer, and it needs no PLL and no majority voting. The decoder relies on one property of the code: a real mid-bit transition comes once every bit period. Any transition that falls less than one bit period after it can only be a boundary transition between two equal bits. A transition that arrives while the timer is idle is taken as a mid-bit event. At that event the decoder captures the line level and starts a hold-off window of about three quarters of a bit. Every transition inside that window is discarded.

The line input first passes through a synchroniser. Edges are found by comparing successive synchronised samples. A rising mid-bit transition stands for a 0, and a falling one stands for a 1. The stored bit is therefore the inverse of the line level just after the accepted edge. The decoder drives the bit and its complement, so the polarity the receiving UART needs can be chosen at integration time. A one-cycle strobe marks each new bit. The decoder locks correctly only if the first transition it sees is a mid-bit transition. The line is expected to be low when reset ends, and a frame should open with a 0 bit.

Top module: `manchester_oneshot_decoder`

## Requirements
- R1: While reset is held and on the first cycle after it, `bit_o` is 1, `bit_n_o` is 0 and `bit_valid_o` is 0.
- R2: An accepted rising line edge yields `bit_o` = 0. An accepted falling edge yields `bit_o` = 1.
- R3: A line change that is accepted shows on `bit_o` and `bit_valid_o` after the third rising clock edge following the change, and not after the second.
- R4: A line change that comes 1 to `HOLDOFF` sample cycles after an accepted change is ignored. It raises no strobe and leaves `bit_o` unchanged.
- R5: A line change that comes exactly `HOLDOFF`+1 sample cycles after an accepted change is accepted. An ignored change does not restart the window.
- R6: `bit_valid_o` is high for exactly one sample cycle for each accepted edge.
- R7: `bit_n_o` is always the complement of `bit_o`.
- R8: A continuous Manchester stream at `OVERSAMPLE` cycles per bit, which opens with a 0 bit from a low line, is decoded in order. This holds for alternating bits, for long runs of equal bits and for mixed patterns. In the code a 0 is low-then-high and a 1 is high-then-low.
- R9: `bit_o` holds its value in every cycle in which `bit_valid_o` is low.
- R10: When the line does not change, `bit_valid_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, `OVERSAMPLE` times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Squared Manchester line, asynchronous to `clk` |
| bit_o | output | 1 | Decoded data bit, true polarity |
| bit_n_o | output | 1 | Decoded data bit, inverted polarity |
| bit_valid_o | output | 1 | One-cycle strobe that marks a new decoded bit |

## Verification
Two events can land in the same cycle: the hold-off timer returns to idle, and a new synchronised edge arrives. The outcome depends on which of them the decoder treats as first. A directed sequence spaces two line changes `HOLDOFF` cycles apart, and the second change must be dropped with `bit_o` held. The same sequence is then repeated with a spacing of `HOLDOFF`+1 cycles, and the second change must now be decoded as a 1. A scoreboard compares every strobe against the queued expected bits. It reports any extra strobe, any missing strobe, any wrong value and any change of `bit_o` between strobes.

// File: rtl/mdec_pkg.sv
// Shared definitions for the Manchester hold-off decoder.
// Assumes nothing beyond integer oversampling ratios of at least 4.
package mdec_pkg;

    // Default hold-off: three quarters of a bit period in sample cycles.
    function automatic int unsigned holdoff_for(input int unsigned oversample);
        return (oversample * 3) / 4;
    endfunction

    // Counter width that can hold the value n.
    function automatic int unsigned width_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/mdec_line_sync.sv
// Synchroniser and edge detector for the asynchronous line input.
// Assumes the line is low when reset ends; all stages reset to 0.
module mdec_line_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic edge_o
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [LAST:0] stage_q;
    logic          prev_q;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw line.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= 1'b0;
                    else        stage_q[0] <= line_i;
                end
            end else begin : g_rest
                // Later stages shift the sample along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= 1'b0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    // Keep the previous synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= stage_q[LAST];
    end

    // Level and edge presented to the decoder.
    always_comb begin
        level_o = stage_q[LAST];
        edge_o  = stage_q[LAST] ^ prev_q;
    end

    // R10: an edge flag implies the synchronised level moved since last cycle.
    a_r10_edge_is_change: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> (prev_q == $past(level_o)));

endmodule

// File: rtl/mdec_holdoff_timer.sv
// Digital one-shot: loads HOLDOFF on start and counts down to idle.
// Assumes start only arrives while idle; it is not retriggered by later edges.
module mdec_holdoff_timer #(
    parameter int unsigned HOLDOFF = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic idle_o
);
    localparam int unsigned CW = mdec_pkg::width_for(HOLDOFF);
    localparam logic [CW-1:0] LOAD = CW'(HOLDOFF);

    logic [CW-1:0] cnt_q;

    // Load on start, otherwise run down to zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (start_i)       cnt_q <= LOAD;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    // Idle when the window has fully elapsed.
    always_comb idle_o = (cnt_q == '0);

    // R5: a start always opens a full window.
    a_r5_full_reload: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_q == LOAD));

    // R4: a running window steps down by one each cycle without restart.
    a_r4_steady_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/mdec_bit_capture.sv
// Output register: stores the inverse of the line level on each accepted edge.
// Assumes trig_i is a single-cycle pulse; resets to 1 (UART idle mark).
module mdec_bit_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic level_i,
    output logic bit_o,
    output logic bit_n_o,
    output logic valid_o
);
    logic data_q;
    logic valid_q;

    // Capture the decoded bit: rising mid-bit means 0, falling means 1.
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= 1'b1;
        else if (trig_i) data_q <= ~level_i;
    end

    // Strobe follows the trigger by one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= trig_i;
    end

    // Drive both polarities and the strobe.
    always_comb begin
        bit_o   = data_q;
        bit_n_o = ~data_q;
        valid_o = valid_q;
    end

    // R9: the bit moves only alongside a strobe.
    a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> $stable(data_q));

endmodule

// File: rtl/manchester_oneshot_decoder.sv
// Manchester decoder with hold-off based clock recovery.
// Assumes the line is already squared, low at reset release, and the stream
// starts with a mid-bit transition; HOLDOFF must lie between OVERSAMPLE/2
// and OVERSAMPLE-1.
module manchester_oneshot_decoder #(
    parameter int unsigned OVERSAMPLE  = 16,
    parameter int unsigned HOLDOFF     = mdec_pkg::holdoff_for(OVERSAMPLE),
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic bit_o,
    output logic bit_n_o,
    output logic bit_valid_o
);
    logic level;
    logic line_edge;
    logic timer_idle;
    logic accept;

    mdec_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .level_o(level),
        .edge_o (line_edge)
    );

    // Only an edge seen with the timer idle counts as a mid-bit event.
    always_comb accept = line_edge & timer_idle;

    mdec_holdoff_timer #(.HOLDOFF(HOLDOFF)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(accept),
        .idle_o (timer_idle)
    );

    mdec_bit_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (accept),
        .level_i(level),
        .bit_o  (bit_o),
        .bit_n_o(bit_n_o),
        .valid_o(bit_valid_o)
    );

    // R4: an edge during the window produces no strobe.
    a_r4_busy_edge_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (line_edge && !timer_idle) |=> !bit_valid_o);

    // R10: every strobe is caused by an edge one cycle earlier.
    a_r10_strobe_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |-> $past(line_edge));

    // R2: the stored bit is the inverse of the post-edge level.
    a_r2_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (bit_o == !$past(level)));

    // R6: strobes never come back to back.
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |=> !bit_valid_o);

endmodule

// File: tb/manchester_oneshot_decoder_test.sv
module manchester_oneshot_decoder_test;
    localparam int unsigned OS   = 16;
    localparam int unsigned HO   = (OS * 3) / 4;
    localparam int unsigned HALF = OS / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_i = 1'b0;
    logic bit_o, bit_n_o, bit_valid_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    logic exp_q[$];
    logic last_bit = 1'b1;
    logic last_valid = 1'b0;

    always #2 clk = ~clk;

    manchester_oneshot_decoder #(.OVERSAMPLE(OS)) uut (
        .clk(clk), .rst_n(rst_n), .line_i(line_i),
        .bit_o(bit_o), .bit_n_o(bit_n_o), .bit_valid_o(bit_valid_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pops one expected bit per strobe and watches the invariants.
    always @(negedge clk) begin
        if (mon_on) begin
            check(bit_n_o == ~bit_o, "R7 complement", bit_n_o, ~bit_o);
            if (bit_valid_o) begin
                check(!last_valid, "R6 strobe width", last_valid, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4/R10 unexpected strobe", 1, 0);
                end else begin
                    logic e;
                    e = exp_q.pop_front();
                    check(bit_o == e, "R8 decoded bit", bit_o, e);
                end
                last_bit = bit_o;
            end else begin
                check(bit_o == last_bit, "R9 hold between strobes", bit_o, last_bit);
            end
            last_valid = bit_valid_o;
        end
    end

    // Driver: one Manchester bit, first half at b, second half at ~b.
    task automatic send_bit(input logic b);
        exp_q.push_back(b);
        line_i = b;
        repeat (HALF) @(negedge clk);
        line_i = ~b;
        repeat (OS - HALF) @(negedge clk);
    endtask

    // Frame: leading 0 to lock, payload LSB first, trailing 1 to end low.
    task automatic send_frame(input logic [63:0] v, input int n);
        send_bit(1'b0);
        for (int i = 0; i < n; i++) send_bit(v[i]);
        send_bit(1'b1);
        repeat (3 * OS) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] lf;
        repeat (4) @(negedge clk);
        // R1: reset values while held.
        check(bit_o == 1'b1, "R1 bit in reset", bit_o, 1);
        check(bit_n_o == 1'b0, "R1 bit_n in reset", bit_n_o, 0);
        check(bit_valid_o == 1'b0, "R1 valid in reset", bit_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bit_o == 1'b1 && !bit_valid_o, "R1 after reset", bit_o, 1);
        mon_on = 1'b1;

        // R10: quiet line gives no strobe (monitor flags any).
        repeat (40) @(negedge clk);
        check(!bit_valid_o && bit_o == 1'b1, "R10 quiet line", bit_valid_o, 0);

        // R3 and R2: rising change, latency of three clock edges.
        exp_q.push_back(1'b0);
        line_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(bit_valid_o == 1'b0, "R3 not after two edges", bit_valid_o, 0);
        @(negedge clk);
        check(bit_valid_o == 1'b1, "R3 strobe after three edges", bit_valid_o, 1);
        check(bit_o == 1'b0, "R2 rising gives 0", bit_o, 0);
        // R4/R5: opposite change exactly HO cycles after the first one: ignored.
        repeat (HO - 3) @(negedge clk);
        line_i = 1'b0;
        repeat (8) @(negedge clk);
        check(bit_o == 1'b0, "R4 change at window end ignored", bit_o, 0);
        repeat (2 * OS) @(negedge clk);

        // R5: spacing HO+1 is accepted; falling gives 1.
        exp_q.push_back(1'b0);
        line_i = 1'b1;
        repeat (HO + 1) @(negedge clk);
        exp_q.push_back(1'b1);
        line_i = 1'b0;
        repeat (4) @(negedge clk);
        check(bit_o == 1'b1, "R5 change after window accepted", bit_o, 1);
        check(exp_q.size() == 0, "R5 both strobes seen", exp_q.size(), 0);
        repeat (2 * OS) @(negedge clk);

        // R8: streams with different patterns.
        send_frame(64'hAAAA, 16);
        send_frame(64'hFFF, 12);
        send_frame(64'h000, 12);
        lf = 64'h1;
        for (int i = 0; i < 48; i++) lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59] ^ 1'b1};
        send_frame(lf, 48);
        check(exp_q.size() == 0, "R8 all bits decoded", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule